// File: doc/BRIEF.md
# Interrupt Source State Controller

This block is the source stage of an interrupt controller. It keeps one state entry for each of `NUM_SRC` interrupt sources. Sources are addressed by global numbers that begin at `BASE` (4096 by default). Each entry holds a destination server, a live priority, a saved priority and four status flags. A strap input marks each source as either level-sensitive or message-signalled, and the two kinds use different flags. The priority value 0xFF means the source is masked.

All traffic enters through one command port. The commands are:
- a source event
- configuration: set target, switch off, switch on, query
- the presentation stage's reject, end-of-interrupt and resend requests

A command is taken in any cycle where `busy` is low. A command that arrives while `busy` is high is dropped. When a command decides that a source must be presented, the block places an offer (server, global number, priority) in a single registered slot on a valid/ready output. A resend request starts a scan that visits one source per cycle in ascending order. The scan holds `busy` high until it has visited the last source. Configuration commands answer with a one-cycle response that carries an error flag and the entry's resulting server and priority.

Top module: `irq_source_ctl`

## Requirements
- R1: A configuration command (set target `cmdOp`=1, off 2, on 3, query 4) gets a parameter error (`rspValid`=1, `rspErr`=1) and changes no state in three cases: its number lies outside [BASE, BASE+NUM_SRC); or it is a set-target with `cmdServer` >= NUM_SERVERS; or it is a set-target with `cmdPrio` > 255. Events (0), rejects (5) and EOIs (6) that carry an out-of-range number are ignored.
- R2: An event (`cmdOp`=0, `cmdLevel`=1) on a message source whose priority is not 0xFF presents an offer with that entry's server, its global number and its priority, one cycle after the command is accepted. If the priority is 0xFF, no offer is made and the source becomes masked-pending.
- R3: An event on a level source sets the source's asserted flag to `cmdLevel`. A level source is offered only when three things hold: its priority is not 0xFF, it is asserted, and it is not already marked sent. Offering it marks it sent.
- R4: A reject (`cmdOp`=5) marks the named source rejected and clears its sent mark.
- R5: An EOI (`cmdOp`=6) clears the sent mark of a level source. An EOI has no effect on a message source.
- R6: A set-target writes the server, the priority and the saved priority. For a message source that is masked-pending and whose new priority is not 0xFF, the write clears masked-pending and offers the source. For a level source, the write applies the level offer rule of R3. The response carries the new server and priority.
- R7: Switch-off sets the priority to 0xFF and copies the old priority into the saved priority. Switch-on copies the saved priority back into the priority. After either one, the offer rules of R6 apply.
- R8: A query answers one cycle later with `rspErr`=0 and the entry's server and priority, and changes nothing.
- R9: A resend (`cmdOp`=7) makes `busy` high from the next cycle. The scan then visits one source per cycle in ascending number. On a message source that is marked rejected, it clears the mark and offers the source unless the priority is 0xFF. On a level source, it applies the rule of R3.
- R10: While `offerValid` is high and `offerReady` is low, the offer stays stable and `busy` stays high. Commands presented while `busy` is high are ignored.
- R11: Reset clears every status flag, sets every priority and saved priority to 0xFF, sets every server to 0, and leaves `offerValid`, `busy` and `rspValid` low.
- R12: Bit i of `srcIsLevel` selects the type of local source i (1 = level, 0 = message). Reset does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIsLevel | input | NUM_SRC | Per-source type strap, 1 = level |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 3 | 0 event, 1 set target, 2 off, 3 on, 4 query, 5 reject, 6 EOI, 7 resend |
| cmdNum | input | NUM_W | Global source number |
| cmdServer | input | 8 | Target server for set target |
| cmdPrio | input | 9 | Priority for set target (above 255 is an error) |
| cmdLevel | input | 1 | Event value |
| busy | output | 1 | Commands are being dropped |
| rspValid | output | 1 | Configuration response pulse |
| rspErr | output | 1 | Parameter error |
| rspServer | output | SRV_W | Entry server after the command |
| rspPrio | output | 8 | Entry priority after the command |
| offerValid | output | 1 | Offer present |
| offerReady | input | 1 | Presentation stage takes the offer |
| offerServer | output | SRV_W | Offered server |
| offerNum | output | NUM_W | Offered global number |
| offerPrio | output | 8 | Offered priority |

## Verification
Responses and offers that come from an accepted command appear exactly one clock after that command's edge. A resend's first scan step happens one clock after acceptance, and the step for local source i happens i clocks after that, counted while the offer slot is free. `busy` depends on the current `offerReady` as well as on registered state. The bench drives inputs and compares every output on the falling edge against a behavioural model that is updated on the rising edge. Each command is therefore judged in the half-cycle after the edge that consumed it. Directed checks with literal values, and a record of the scan's offers in order, back up the model.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  localparam logic [7:0] PRIO_MASKED = 8'hFF;

  typedef enum logic [2:0] {
    OP_EVENT  = 3'd0,
    OP_TARGET = 3'd1,
    OP_OFF    = 3'd2,
    OP_ON     = 3'd3,
    OP_QUERY  = 3'd4,
    OP_REJECT = 3'd5,
    OP_EOI    = 3'd6,
    OP_RESEND = 3'd7
  } cmd_op_e;

  typedef enum logic [3:0] {
    ACT_NONE,
    ACT_EVENT,
    ACT_TARGET,
    ACT_OFF,
    ACT_ON,
    ACT_QUERY,
    ACT_REJECT,
    ACT_EOI,
    ACT_SCAN
  } act_e;

  typedef struct packed {
    act_e act;
    logic rspEn;
    logic rspErr;
  } strobe_t;

endpackage

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int NUM_SERVERS = 4,
  parameter int BASE        = 4096,
  parameter int NUM_W       = 16,
  parameter int IDX_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  cmd_op_e          cmdOp,
  input  logic [NUM_W-1:0] cmdNum,
  input  logic [7:0]       cmdServer,
  input  logic [8:0]       cmdPrio,
  input  logic             slotFree,
  output strobe_t          strobe,
  output logic [IDX_W-1:0] stepIdx,
  output logic             busy
);

  localparam logic [NUM_W-1:0] NUM_LO  = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] NUM_HI  = NUM_W'(BASE + NUM_SRC);
  localparam logic [8:0]       SRV_LIM = 9'(NUM_SERVERS);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(NUM_SRC - 1);

  logic             scanActive;
  logic [IDX_W-1:0] scanIdx;
  logic             accept;
  logic             numOk;
  logic             srvOk;
  logic [IDX_W-1:0] localIdx;

  assign busy     = scanActive || !slotFree;
  assign accept   = cmdValid && !busy;
  assign numOk    = (cmdNum >= NUM_LO) && (cmdNum < NUM_HI);
  assign srvOk    = {1'b0, cmdServer} < SRV_LIM;
  assign localIdx = IDX_W'(cmdNum - NUM_LO);

  always_comb begin
    strobe  = '{act: ACT_NONE, rspEn: 1'b0, rspErr: 1'b0};
    stepIdx = localIdx;
    if (scanActive) begin
      stepIdx = scanIdx;
      if (slotFree) strobe.act = ACT_SCAN;
    end else if (accept) begin
      case (cmdOp)
        OP_EVENT:  if (numOk) strobe.act = ACT_EVENT;
        OP_REJECT: if (numOk) strobe.act = ACT_REJECT;
        OP_EOI:    if (numOk) strobe.act = ACT_EOI;
        OP_TARGET: begin
          strobe.rspEn = 1'b1;
          if (numOk && srvOk && !cmdPrio[8]) strobe.act = ACT_TARGET;
          else strobe.rspErr = 1'b1;
        end
        OP_OFF, OP_ON, OP_QUERY: begin
          strobe.rspEn = 1'b1;
          if (!numOk) strobe.rspErr = 1'b1;
          else if (cmdOp == OP_OFF) strobe.act = ACT_OFF;
          else if (cmdOp == OP_ON) strobe.act = ACT_ON;
          else strobe.act = ACT_QUERY;
        end
        default: strobe.act = ACT_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanActive <= 1'b0;
      scanIdx    <= '0;
    end else if (!scanActive) begin
      if (accept && cmdOp == OP_RESEND) begin
        scanActive <= 1'b1;
        scanIdx    <= '0;
      end
    end else if (slotFree) begin
      if (scanIdx == LAST) scanActive <= 1'b0;
      else scanIdx <= scanIdx + 1'b1;
    end
  end

endmodule

// File: rtl/irq_src_data.sv
module irq_src_data
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRV_W   = 2,
  parameter int BASE    = 4096,
  parameter int NUM_W   = 16,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [IDX_W-1:0]   stepIdx,
  input  logic [NUM_SRC-1:0] srcIsLevel,
  input  logic               cmdLevel,
  input  logic [SRV_W-1:0]   cmdServer,
  input  logic [7:0]         cmdPrio,
  input  logic               offerReady,
  output logic               slotFree,
  output logic               offerValid,
  output logic [SRV_W-1:0]   offerServer,
  output logic [NUM_W-1:0]   offerNum,
  output logic [7:0]         offerPrio,
  output logic               rspValid,
  output logic               rspErr,
  output logic [SRV_W-1:0]   rspServer,
  output logic [7:0]         rspPrio
);

  typedef struct packed {
    logic [SRV_W-1:0] server;
    logic [7:0]       prio;
    logic [7:0]       saved;
    logic             asserted;
    logic             sent;
    logic             rejected;
    logic             maskPend;
  } entry_t;

  localparam logic [NUM_W-1:0] NUM_LO = NUM_W'(BASE);

  entry_t tbl [NUM_SRC];
  entry_t cur;
  entry_t nxt;
  logic   isLevel;
  logic   inRange;
  logic   fire;
  logic   applyWrite;
  logic   writeEn;

  assign inRange  = int'(stepIdx) < NUM_SRC;
  assign cur      = inRange ? tbl[stepIdx] : '0;
  assign isLevel  = inRange ? srcIsLevel[stepIdx] : 1'b0;
  assign slotFree = !offerValid || offerReady;
  assign writeEn  = inRange && (strobe.act != ACT_NONE) && (strobe.act != ACT_QUERY);

  always_comb begin
    nxt        = cur;
    fire       = 1'b0;
    applyWrite = 1'b0;
    case (strobe.act)
      ACT_EVENT: begin
        if (isLevel) begin
          nxt.asserted = cmdLevel;
          applyWrite   = 1'b1;
        end else if (cmdLevel) begin
          if (cur.prio == PRIO_MASKED) nxt.maskPend = 1'b1;
          else fire = 1'b1;
        end
      end
      ACT_TARGET: begin
        nxt.server = cmdServer;
        nxt.prio   = cmdPrio;
        nxt.saved  = cmdPrio;
        applyWrite = 1'b1;
      end
      ACT_OFF: begin
        nxt.prio   = PRIO_MASKED;
        nxt.saved  = cur.prio;
        applyWrite = 1'b1;
      end
      ACT_ON: begin
        nxt.prio   = cur.saved;
        applyWrite = 1'b1;
      end
      ACT_REJECT: begin
        nxt.rejected = 1'b1;
        nxt.sent     = 1'b0;
      end
      ACT_EOI: if (isLevel) nxt.sent = 1'b0;
      ACT_SCAN: begin
        if (isLevel) applyWrite = 1'b1;
        else if (cur.rejected) begin
          nxt.rejected = 1'b0;
          fire         = (cur.prio != PRIO_MASKED);
        end
      end
      default: ;
    endcase
    // shared offer rules after a state change
    if (applyWrite) begin
      if (isLevel) begin
        if (nxt.prio != PRIO_MASKED && nxt.asserted && !nxt.sent) begin
          nxt.sent = 1'b1;
          fire     = 1'b1;
        end
      end else if (nxt.maskPend && nxt.prio != PRIO_MASKED) begin
        nxt.maskPend = 1'b0;
        fire         = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        tbl[i] <= '{server: '0, prio: PRIO_MASKED, saved: PRIO_MASKED,
                    asserted: 1'b0, sent: 1'b0, rejected: 1'b0, maskPend: 1'b0};
      end
    end else if (writeEn) begin
      tbl[stepIdx] <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offerValid  <= 1'b0;
      offerServer <= '0;
      offerNum    <= '0;
      offerPrio   <= '0;
    end else if (fire) begin
      offerValid  <= 1'b1;
      offerServer <= nxt.server;
      offerNum    <= NUM_LO + NUM_W'(stepIdx);
      offerPrio   <= nxt.prio;
    end else if (offerReady) begin
      offerValid  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspErr    <= 1'b0;
      rspServer <= '0;
      rspPrio   <= '0;
    end else begin
      rspValid  <= strobe.rspEn;
      rspErr    <= strobe.rspErr;
      rspServer <= strobe.rspErr ? '0 : nxt.server;
      rspPrio   <= strobe.rspErr ? '0 : nxt.prio;
    end
  end

endmodule

// File: rtl/irq_source_ctl.sv
module irq_source_ctl
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int NUM_SERVERS = 4,
  parameter int BASE        = 4096,
  parameter int NUM_W       = 16,
  localparam int SRV_W      = (NUM_SERVERS > 1) ? $clog2(NUM_SERVERS) : 1,
  localparam int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIsLevel,
  input  logic               cmdValid,
  input  logic [2:0]         cmdOp,
  input  logic [NUM_W-1:0]   cmdNum,
  input  logic [7:0]         cmdServer,
  input  logic [8:0]         cmdPrio,
  input  logic               cmdLevel,
  output logic               busy,
  output logic               rspValid,
  output logic               rspErr,
  output logic [SRV_W-1:0]   rspServer,
  output logic [7:0]         rspPrio,
  output logic               offerValid,
  input  logic               offerReady,
  output logic [SRV_W-1:0]   offerServer,
  output logic [NUM_W-1:0]   offerNum,
  output logic [7:0]         offerPrio
);

  strobe_t          strobe;
  logic [IDX_W-1:0] stepIdx;
  logic             slotFree;

  irq_src_ctrl #(
    .NUM_SRC(NUM_SRC), .NUM_SERVERS(NUM_SERVERS), .BASE(BASE),
    .NUM_W(NUM_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmd_op_e'(cmdOp)),
    .cmdNum(cmdNum), .cmdServer(cmdServer), .cmdPrio(cmdPrio),
    .slotFree(slotFree), .strobe(strobe), .stepIdx(stepIdx), .busy(busy)
  );

  irq_src_data #(
    .NUM_SRC(NUM_SRC), .SRV_W(SRV_W), .BASE(BASE), .NUM_W(NUM_W), .IDX_W(IDX_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stepIdx(stepIdx),
    .srcIsLevel(srcIsLevel), .cmdLevel(cmdLevel),
    .cmdServer(cmdServer[SRV_W-1:0]), .cmdPrio(cmdPrio[7:0]),
    .offerReady(offerReady), .slotFree(slotFree),
    .offerValid(offerValid), .offerServer(offerServer), .offerNum(offerNum),
    .offerPrio(offerPrio), .rspValid(rspValid), .rspErr(rspErr),
    .rspServer(rspServer), .rspPrio(rspPrio)
  );

endmodule

// File: rtl/irq_source_ctl_chk.sv
module irq_source_ctl_chk #(
  parameter int NUM_SRC = 8,
  parameter int BASE    = 4096,
  parameter int NUM_W   = 16,
  parameter int SRV_W   = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [2:0]       cmdOp,
  input logic [8:0]       cmdPrio,
  input logic             busy,
  input logic             rspValid,
  input logic             rspErr,
  input logic             offerValid,
  input logic             offerReady,
  input logic [SRV_W-1:0] offerServer,
  input logic [NUM_W-1:0] offerNum,
  input logic [7:0]       offerPrio
);

  logic taken;
  assign taken = cmdValid && !busy;

  p_offer_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    offerValid && !offerReady |=> offerValid && $stable(offerNum)
      && $stable(offerServer) && $stable(offerPrio));

  p_stall_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    offerValid && !offerReady |-> busy);

  p_offer_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    offerValid |-> (offerNum >= NUM_W'(BASE)) && (offerNum < NUM_W'(BASE + NUM_SRC)));

  p_prio_err_r1: assert property (@(posedge clk) disable iff (!rstN)
    taken && cmdOp == 3'd1 && cmdPrio[8] |=> rspValid && rspErr);

  p_off_silent_r7: assert property (@(posedge clk) disable iff (!rstN)
    taken && cmdOp == 3'd2 |=> !offerValid);

  p_scan_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    taken && cmdOp == 3'd7 |=> busy);

endmodule

bind irq_source_ctl irq_source_ctl_chk #(
  .NUM_SRC(NUM_SRC), .BASE(BASE), .NUM_W(NUM_W), .SRV_W(SRV_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdPrio(cmdPrio),
  .busy(busy), .rspValid(rspValid), .rspErr(rspErr), .offerValid(offerValid),
  .offerReady(offerReady), .offerServer(offerServer), .offerNum(offerNum),
  .offerPrio(offerPrio)
);

// File: tb/irq_source_ctl_tb.sv
module irq_source_ctl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int B = 4096;
  localparam logic [7:0] LVL_MASK = 8'hF0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] srcIsLevel = LVL_MASK;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [15:0] cmdNum = 16'd0;
  logic [7:0] cmdServer = 8'd0;
  logic [8:0] cmdPrio = 9'd0;
  logic cmdLevel = 1'b0;
  logic offerReady = 1'b1;
  logic busy, rspValid, rspErr, offerValid;
  logic [1:0] rspServer, offerServer;
  logic [7:0] rspPrio, offerPrio;
  logic [15:0] offerNum;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_source_ctl u_dut (
    .clk(clk), .rstN(rstN), .srcIsLevel(srcIsLevel), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdNum(cmdNum), .cmdServer(cmdServer), .cmdPrio(cmdPrio),
    .cmdLevel(cmdLevel), .busy(busy), .rspValid(rspValid), .rspErr(rspErr),
    .rspServer(rspServer), .rspPrio(rspPrio), .offerValid(offerValid),
    .offerReady(offerReady), .offerServer(offerServer), .offerNum(offerNum),
    .offerPrio(offerPrio)
  );

  int checks = 0;
  int fails = 0;
  string curReq = "R11";

  // behavioural reference model
  int mSrv[N], mPri[N], mSav[N];
  bit mAsr[N], mSent[N], mRej[N], mMp[N];
  bit mScan; int mScanIdx;
  bit mOffV; int mOffS, mOffN, mOffP;
  bit mRspV, mRspE; int mRspS, mRspP;
  bit fire; int fIdx;

  function automatic void lvlRule(int i);
    if (mPri[i] != 255 && mAsr[i] && !mSent[i]) begin
      mSent[i] = 1; fire = 1; fIdx = i;
    end
  endfunction

  function automatic void wrRule(int i);
    if (LVL_MASK[i]) lvlRule(i);
    else if (mMp[i] && mPri[i] != 255) begin
      mMp[i] = 0; fire = 1; fIdx = i;
    end
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        mSrv[i] = 0; mPri[i] = 255; mSav[i] = 255;
        mAsr[i] = 0; mSent[i] = 0; mRej[i] = 0; mMp[i] = 0;
      end
      mScan = 0; mScanIdx = 0; mOffV = 0; mRspV = 0; mRspE = 0;
    end else begin
      bit slot;
      bit ok;
      int idx;
      slot = !mOffV || offerReady;
      fire = 0; fIdx = 0;
      mRspV = 0; mRspE = 0;
      if (mScan) begin
        if (slot) begin
          if (LVL_MASK[mScanIdx]) lvlRule(mScanIdx);
          else if (mRej[mScanIdx]) begin
            mRej[mScanIdx] = 0;
            if (mPri[mScanIdx] != 255) begin fire = 1; fIdx = mScanIdx; end
          end
          if (mScanIdx == N-1) mScan = 0; else mScanIdx++;
        end
      end else if (cmdValid && slot) begin
        ok = (cmdNum >= B) && (cmdNum < B + N);
        idx = ok ? int'(cmdNum) - B : 0;
        case (cmdOp)
          3'd0: if (ok) begin
            if (LVL_MASK[idx]) begin mAsr[idx] = cmdLevel; lvlRule(idx); end
            else if (cmdLevel) begin
              if (mPri[idx] == 255) mMp[idx] = 1; else begin fire = 1; fIdx = idx; end
            end
          end
          3'd1, 3'd2, 3'd3, 3'd4: begin
            mRspV = 1;
            if (!ok || (cmdOp == 3'd1 && (cmdServer >= 4 || cmdPrio > 255))) begin
              mRspE = 1; mRspS = 0; mRspP = 0;
            end else begin
              if (cmdOp == 3'd1) begin
                mSrv[idx] = cmdServer; mPri[idx] = cmdPrio; mSav[idx] = cmdPrio; wrRule(idx);
              end else if (cmdOp == 3'd2) begin
                mSav[idx] = mPri[idx]; mPri[idx] = 255; wrRule(idx);
              end else if (cmdOp == 3'd3) begin
                mPri[idx] = mSav[idx]; wrRule(idx);
              end
              mRspS = mSrv[idx]; mRspP = mPri[idx];
            end
          end
          3'd5: if (ok) begin mRej[idx] = 1; mSent[idx] = 0; end
          3'd6: if (ok && LVL_MASK[idx]) mSent[idx] = 0;
          default: begin mScan = 1; mScanIdx = 0; end
        endcase
      end
      if (fire) begin
        mOffV = 1; mOffS = mSrv[fIdx]; mOffN = B + fIdx; mOffP = mPri[fIdx];
      end else if (offerReady) mOffV = 0;
    end
  end

  task automatic check(bit cond, string what, int act, int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit expBusy;
    expBusy = mScan || (mOffV && !offerReady);
    check(busy == expBusy, "busy", busy, expBusy);
    check(offerValid == mOffV, "offerValid", offerValid, mOffV);
    if (mOffV && offerValid) begin
      check(offerNum == mOffN, "offerNum", offerNum, mOffN);
      check(offerServer == mOffS, "offerServer", offerServer, mOffS);
      check(offerPrio == mOffP, "offerPrio", offerPrio, mOffP);
    end
    check(rspValid == mRspV, "rspValid", rspValid, mRspV);
    if (mRspV && rspValid) begin
      check(rspErr == mRspE, "rspErr", rspErr, mRspE);
      check(rspServer == mRspS, "rspServer", rspServer, mRspS);
      check(rspPrio == mRspP, "rspPrio", rspPrio, mRspP);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  task automatic issue(int op, int num, int srv, int prio, bit lvl);
    cmdValid = 1; cmdOp = 3'(op); cmdNum = 16'(num);
    cmdServer = 8'(srv); cmdPrio = 9'(prio); cmdLevel = lvl;
    tick();
    cmdValid = 0;
  endtask

  task automatic expectOffer(int num, int srv, int prio);
    check(offerValid == 1, "direct offerValid", offerValid, 1);
    check(offerNum == num, "direct offerNum", offerNum, num);
    check(offerServer == srv, "direct offerServer", offerServer, srv);
    check(offerPrio == prio, "direct offerPrio", offerPrio, prio);
  endtask

  task automatic expectNoOffer();
    check(offerValid == 0, "direct no offer", offerValid, 0);
  endtask

  task automatic expectRsp(bit err, int srv, int prio);
    check(rspValid == 1, "direct rspValid", rspValid, 1);
    check(rspErr == err, "direct rspErr", rspErr, err);
    if (!err) begin
      check(rspServer == srv, "direct rspServer", rspServer, srv);
      check(rspPrio == prio, "direct rspPrio", rspPrio, prio);
    end
  endtask

  int seen[$];
  task automatic collect(int cycles);
    seen.delete();
    for (int c = 0; c < cycles; c++) begin
      tick();
      if (offerValid) seen.push_back(int'(offerNum));
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R11 reset state
    curReq = "R11";
    tick(); tick();
    check(offerValid == 0 && busy == 0 && rspValid == 0, "reset idle outputs", offerValid, 0);
    rstN = 1;
    tick();
    issue(4, B, 0, 0, 0);
    expectRsp(0, 0, 255);

    // R6 / R8 configuration of a message source
    curReq = "R6";
    issue(1, B+1, 2, 5, 0);
    expectRsp(0, 2, 5); expectNoOffer();
    curReq = "R8";
    issue(4, B+1, 0, 0, 0);
    expectRsp(0, 2, 5);

    // R2 message events
    curReq = "R2";
    issue(0, B+1, 0, 0, 1);
    expectOffer(B+1, 2, 5);
    issue(0, B+2, 0, 0, 1);
    expectNoOffer();
    curReq = "R6";
    issue(1, B+2, 1, 3, 0);
    expectOffer(B+2, 1, 3);
    issue(1, B+2, 1, 3, 0);
    expectNoOffer();

    // R3 / R12 level source
    curReq = "R12";
    issue(1, B+5, 3, 7, 0);
    expectNoOffer();
    issue(0, B+5, 0, 0, 1);
    expectOffer(B+5, 3, 7);
    curReq = "R3";
    issue(0, B+5, 0, 0, 1);
    expectNoOffer();
    curReq = "R5";
    issue(6, B+5, 0, 0, 0);
    expectNoOffer();
    curReq = "R9";
    issue(7, 0, 0, 0, 0);
    check(busy == 1, "busy after resend", busy, 1);
    collect(10);
    check(seen.size() == 1, "scan offer count", seen.size(), 1);
    if (seen.size() == 1) check(seen[0] == B+5, "scan offer level", seen[0], B+5);

    // R4 reject and ordered rescan
    curReq = "R4";
    issue(5, B+2, 0, 0, 0);
    issue(5, B+1, 0, 0, 0);
    expectNoOffer();
    issue(7, 0, 0, 0, 0);
    collect(10);
    check(seen.size() == 2, "rescan count", seen.size(), 2);
    if (seen.size() == 2) begin
      curReq = "R9";
      check(seen[0] == B+1, "rescan first", seen[0], B+1);
      check(seen[1] == B+2, "rescan second", seen[1], B+2);
    end

    // R5 EOI on message has no effect; level deassert blocks offer (R3)
    curReq = "R5";
    issue(5, B+1, 0, 0, 0);
    issue(6, B+1, 0, 0, 0);
    issue(0, B+5, 0, 0, 0);
    issue(6, B+5, 0, 0, 0);
    issue(7, 0, 0, 0, 0);
    collect(10);
    check(seen.size() == 1, "eoi rescan count", seen.size(), 1);
    if (seen.size() == 1) check(seen[0] == B+1, "eoi rescan num", seen[0], B+1);

    // R7 off / on
    curReq = "R7";
    issue(2, B+1, 0, 0, 0);
    expectRsp(0, 2, 255); expectNoOffer();
    issue(0, B+1, 0, 0, 1);
    expectNoOffer();
    issue(3, B+1, 0, 0, 0);
    expectRsp(0, 2, 5); expectOffer(B+1, 2, 5);

    // R1 parameter errors
    curReq = "R1";
    issue(1, B-1, 0, 1, 0);   expectRsp(1, 0, 0);
    issue(1, B+N, 0, 1, 0);   expectRsp(1, 0, 0);
    issue(1, B+1, 4, 1, 0);   expectRsp(1, 0, 0);
    issue(1, B+1, 0, 256, 0); expectRsp(1, 0, 0);
    issue(2, 9, 0, 0, 0);     expectRsp(1, 0, 0);
    issue(4, B+1, 0, 0, 0);   expectRsp(0, 2, 5);
    issue(0, 5000, 0, 0, 1);  expectNoOffer();

    // R10 back-pressure
    curReq = "R10";
    offerReady = 0;
    issue(0, B+1, 0, 0, 1);
    expectOffer(B+1, 2, 5);
    check(busy == 1, "busy stalled", busy, 1);
    issue(0, B+2, 0, 0, 1);
    expectOffer(B+1, 2, 5);
    tick(); tick();
    expectOffer(B+1, 2, 5);
    offerReady = 1;
    tick();
    expectNoOffer();
    tick();
    expectNoOffer();

    // R11 / R12 second reset keeps type
    curReq = "R11";
    rstN = 0;
    tick(); tick();
    rstN = 1;
    tick();
    issue(4, B+1, 0, 0, 0);
    expectRsp(0, 0, 255);
    curReq = "R12";
    issue(1, B+5, 0, 9, 0);
    expectNoOffer();
    issue(0, B+5, 0, 0, 1);
    expectOffer(B+5, 0, 9);
    issue(0, B+5, 0, 0, 1);
    expectNoOffer();
    tick();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule